// File: doc/BRIEF.md
# Management-Mode Entry/Exit and NMI Gate Controller

This block follows a processor core into and out of its system-management mode. A management interrupt request moves the block into management mode and produces a one-cycle entry strobe. A decoded resume-instruction retire strobe moves it back to normal mode and produces a one-cycle resume strobe. The resume strobe carries a flag that tells the core whether to go back into the halt state.

While the core is in management mode, non-maskable interrupts are gated. One request that arrives while the gate is closed is held and released later. A retire of an interrupt-return instruction inside the handler opens the gate early. Software interrupts do not pass through this block.

The handler sees a small register port with two locations. One is a 16-bit halt-restart register, whose bit 0 records whether the core was halted when management mode was taken. The other is a fixed 32-bit revision identifier.

Top module: `smm_ctl`

## Requirements
- R1: After reset the block is in normal mode, `smm_active`, `smm_enter`, `nmi_deliver`, `resume_valid` and `resume_halt` are 0, and the halt-restart register reads 0.
- R2: `smi_req` in normal mode sets `smm_active` after the next clock edge, and `smm_enter` is high for exactly that one cycle.
- R3: `smi_req` while `smm_active` is 1 is ignored: no `smm_enter` pulse, and the mode is unchanged.
- R4: In normal mode, `nmi_req` gives a one-cycle `nmi_deliver` pulse after the next clock edge.
- R5: From the entry cycle until an interrupt-return retire or a resume retire, `nmi_req` is not delivered. The first such request is held pending, and any further requests while one is pending are dropped.
- R6: On a resume retire with a request pending, `nmi_deliver` pulses in the same cycle as `resume_valid`, so the interrupt is taken before the interrupted code continues. The pending latch is cleared at the same time, and only one pulse results.
- R7: `iret_retire` in management mode opens the gate. A pending request is delivered as a one-cycle pulse after that edge, and later requests are delivered as in R4. `iret_retire` in normal mode has no effect.
- R8: On entry, bit 0 of the halt-restart register (`reg_sel`=0) is loaded with `core_halted`. Bits 31:1 of `reg_rdata` read 0 at this location.
- R9: A write to `reg_sel`=0 in management mode loads `reg_wdata[0]` into bit 0. A write of 1 is ignored when the value captured on entry was 0. Writes in normal mode are ignored.
- R10: `smm_active` together with `rsm_retire` clears `smm_active` and gives a one-cycle `resume_valid`, with `resume_halt` equal to bit 0 of the halt-restart register.
- R11: `reg_sel`=1 reads the revision identifier 32'h0003_0000. This is level 0000h in bits 15:0, 1 in bit 16 and 1 in bit 17, and 0 in bits 31:18. Writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smi_req | input | 1 | Management interrupt request pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| core_halted | input | 1 | Core is in the halt state |
| rsm_retire | input | 1 | Resume instruction retired |
| iret_retire | input | 1 | Interrupt-return instruction retired |
| reg_sel | input | 1 | 0 = halt-restart register, 1 = revision identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| smm_active | output | 1 | Core is in management mode |
| smm_enter | output | 1 | One-cycle entry strobe |
| nmi_deliver | output | 1 | One-cycle interrupt request to the core |
| resume_valid | output | 1 | One-cycle resume strobe |
| resume_halt | output | 1 | With resume_valid: re-enter the halt state |

## Verification
The assertions check the following on every cycle:
- the entry and resume strobes are single-cycle and follow their requests;
- a second management request is ignored while in management mode;
- no interrupt reaches the core while the gate is closed;
- the read data has the fixed revision pattern and the zero upper bits of the halt-restart register.

Some behaviour depends on what happened several cycles earlier, so only the bench's scenarios can show it:
- a single held request is released exactly once, on resume or on interrupt return;
- a second request while one is pending is dropped;
- the halt flag carried on resume follows the captured and written halt-restart bit, including a write of 1 that is refused.

// File: rtl/smm_pkg.sv
// Package: shared constants and helpers for the management-mode controller.
// Assumes a 32-bit identifier and a 16-bit halt-restart register.
package smm_pkg;
    localparam int ID_W = 32;
    localparam int HR_W = 16;
    localparam logic [15:0] REV_LEVEL = 16'h0000;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SMM    = 1'b1
    } smm_mode_t;

    // Builds the revision identifier word from its fields.
    function automatic logic [ID_W-1:0] rev_word(input logic [15:0] level,
                                                 input logic io_trap,
                                                 input logic relocation);
        logic [ID_W-1:0] w;
        w          = '0;
        w[15:0]    = level;
        w[16]      = io_trap;
        w[17]      = relocation;
        return w;
    endfunction
endpackage

// File: rtl/smm_mode_fsm.sv
// Mode tracker: moves between normal and management mode.
// Produces the entry and resume strobes and captures the resume halt flag.
// Assumes request and retire inputs are single-cycle strobes.
module smm_mode_fsm
    import smm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smi_req,
    input  logic rsm_retire,
    input  logic halt_bit,
    output logic enter_now,
    output logic exit_now,
    output logic active,
    output logic enter_pulse,
    output logic resume_pulse,
    output logic resume_halt
);
    smm_mode_t mode_q;

    // Decode accepted transitions from the current mode.
    always_comb begin
        enter_now = (mode_q == MODE_NORMAL) && smi_req;
        exit_now  = (mode_q == MODE_SMM) && rsm_retire;
    end

    // Mode register and the strobes that report its transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MODE_NORMAL;
            enter_pulse  <= 1'b0;
            resume_pulse <= 1'b0;
            resume_halt  <= 1'b0;
        end else begin
            enter_pulse  <= enter_now;
            resume_pulse <= exit_now;
            resume_halt  <= exit_now ? halt_bit : 1'b0;
            if (enter_now)
                mode_q <= MODE_SMM;
            else if (exit_now)
                mode_q <= MODE_NORMAL;
        end
    end

    assign active = (mode_q == MODE_SMM);
endmodule

// File: rtl/smm_nmi_gate.sv
// NMI gate: closes on entry, opens on interrupt return in the handler or on
// resume. Holds one request while closed and delivers one-cycle pulses.
// Assumes nmi_req is a single-cycle request strobe.
module smm_nmi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic in_smm,
    input  logic enter_now,
    input  logic exit_now,
    input  logic iret_retire,
    output logic nmi_deliver
);
    logic blocked_q;
    logic pending_q;
    logic closed_now;
    logic open_now;
    logic deliver_nxt;

    // The gate counts as closed in the entry cycle; open events reopen it.
    always_comb begin
        closed_now  = blocked_q || enter_now;
        open_now    = blocked_q && (exit_now || (in_smm && iret_retire));
        deliver_nxt = (open_now && (pending_q || nmi_req)) ||
                      (nmi_req && !closed_now);
    end

    // Gate state, single-deep pending latch and the delivery pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q   <= 1'b0;
            pending_q   <= 1'b0;
            nmi_deliver <= 1'b0;
        end else begin
            nmi_deliver <= deliver_nxt;
            if (enter_now)
                blocked_q <= 1'b1;
            else if (open_now)
                blocked_q <= 1'b0;
            if (open_now)
                pending_q <= 1'b0;
            else if (nmi_req && closed_now)
                pending_q <= 1'b1;
        end
    end
endmodule

// File: rtl/smm_halt_reg.sv
// Halt-restart register: bit 0 is captured on entry and may be cleared by
// the handler. It may be set again only if it was set on entry; the upper
// bits read zero. Assumes wr_en is already qualified by management mode.
module smm_halt_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_now,
    input  logic             core_halted,
    input  logic             wr_en,
    input  logic             wr_bit,
    output logic [WIDTH-1:0] value
);
    logic bit_q;
    logic entry_q;

    // Capture on entry; later handler writes are limited by the entry value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            entry_q <= 1'b0;
        end else if (enter_now) begin
            bit_q   <= core_halted;
            entry_q <= core_halted;
        end else if (wr_en) begin
            bit_q   <= wr_bit && entry_q;
        end
    end

    // Present the bit in a register-width word.
    always_comb begin
        value    = '0;
        value[0] = bit_q;
    end
endmodule

// File: rtl/smm_ctl.sv
// Management-mode controller top: joins the mode tracker, the NMI gate and
// the halt-restart register, and multiplexes the handler's read port.
// Assumes all inputs are synchronous to clk.
module smm_ctl
    import smm_pkg::*;
#(
    parameter logic [15:0] REVISION = REV_LEVEL,
    parameter bit          HAS_IO_TRAP = 1'b1,
    parameter bit          HAS_RELOC   = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smi_req,
    input  logic            nmi_req,
    input  logic            core_halted,
    input  logic            rsm_retire,
    input  logic            iret_retire,
    input  logic            reg_sel,
    input  logic            reg_wr,
    input  logic [ID_W-1:0] reg_wdata,
    output logic [ID_W-1:0] reg_rdata,
    output logic            smm_active,
    output logic            smm_enter,
    output logic            nmi_deliver,
    output logic            resume_valid,
    output logic            resume_halt
);
    localparam logic [ID_W-1:0] ID_WORD = rev_word(REVISION, HAS_IO_TRAP, HAS_RELOC);

    logic            enter_now;
    logic            exit_now;
    logic            hr_wr;
    logic [HR_W-1:0] hr_value;

    smm_mode_fsm u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .smi_req      (smi_req),
        .rsm_retire   (rsm_retire),
        .halt_bit     (hr_value[0]),
        .enter_now    (enter_now),
        .exit_now     (exit_now),
        .active       (smm_active),
        .enter_pulse  (smm_enter),
        .resume_pulse (resume_valid),
        .resume_halt  (resume_halt)
    );

    smm_nmi_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_req     (nmi_req),
        .in_smm      (smm_active),
        .enter_now   (enter_now),
        .exit_now    (exit_now),
        .iret_retire (iret_retire),
        .nmi_deliver (nmi_deliver)
    );

    smm_halt_reg #(.WIDTH(HR_W)) u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_now   (enter_now),
        .core_halted (core_halted),
        .wr_en       (hr_wr),
        .wr_bit      (reg_wdata[0]),
        .value       (hr_value)
    );

    // Only handler writes to the halt-restart location are accepted.
    assign hr_wr = reg_wr && !reg_sel && smm_active;

    // Read multiplexer: the fixed identifier or the zero-extended register.
    always_comb begin
        if (reg_sel)
            reg_rdata = ID_WORD;
        else
            reg_rdata = {{(ID_W-HR_W){1'b0}}, hr_value};
    end
endmodule

// File: rtl/smm_ctl_chk.sv
// Checker for smm_ctl: port-level temporal properties, bound to every instance.
// Keeps its own record of whether an interrupt return was seen in the handler.
module smm_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smi_req,
    input logic        nmi_req,
    input logic        rsm_retire,
    input logic        iret_retire,
    input logic        reg_sel,
    input logic [31:0] reg_rdata,
    input logic        smm_active,
    input logic        smm_enter,
    input logic        nmi_deliver,
    input logic        resume_valid
);
    logic gate_open;

    // Shadow of the gate: opened by an interrupt return in the handler.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_open <= 1'b0;
        else if (!smm_active)
            gate_open <= 1'b0;
        else if (iret_retire)
            gate_open <= 1'b1;
    end

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !smm_active) |=> (smm_active && smm_enter));

    p_entry_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smm_enter |=> !smm_enter);

    p_smi_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && !rsm_retire) |=> (smm_active && !smm_enter));

    p_nmi_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !smm_active && !smi_req) |=> nmi_deliver);

    p_nmi_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && !gate_open && !rsm_retire && !iret_retire) |=> !nmi_deliver);

    p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && rsm_retire) |=> (resume_valid && !smm_active));

    p_resume_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |=> !resume_valid);

    p_halt_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[31:1] == 31'd0));

    p_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata == 32'h0003_0000));
endmodule

bind smm_ctl smm_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smi_req      (smi_req),
    .nmi_req      (nmi_req),
    .rsm_retire   (rsm_retire),
    .iret_retire  (iret_retire),
    .reg_sel      (reg_sel),
    .reg_rdata    (reg_rdata),
    .smm_active   (smm_active),
    .smm_enter    (smm_enter),
    .nmi_deliver  (nmi_deliver),
    .resume_valid (resume_valid)
);

// File: tb/sim_smm_ctl.sv
// Bench for smm_ctl: a vector table walked by one loop, then directed tests.
module sim_smm_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smi_req = 1'b0, nmi_req = 1'b0, core_halted = 1'b0;
    logic        rsm_retire = 1'b0, iret_retire = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smm_active, smm_enter, nmi_deliver, resume_valid, resume_halt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smm_ctl u0 (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .nmi_req(nmi_req),
        .core_halted(core_halted), .rsm_retire(rsm_retire), .iret_retire(iret_retire),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smm_active(smm_active), .smm_enter(smm_enter), .nmi_deliver(nmi_deliver),
        .resume_valid(resume_valid), .resume_halt(resume_halt)
    );

    // Inputs {smi,nmi,halted,rsm,iret}; expected {enter,active,deliver,resume,halt}.
    localparam int NV = 16;
    localparam logic [9:0] VEC [NV] = '{
        10'b01000_00100,  // R4 nmi in normal mode
        10'b11100_11000,  // R2 entry (halted), R5 nmi latched
        10'b01000_01000,  // R5 second nmi dropped
        10'b00000_01000,  // R5 still gated
        10'b00010_00111,  // R6 pending delivered with resume; R10 halt=1
        10'b00000_00000,  // R6 only one pulse
        10'b10000_11000,  // R2 entry, not halted
        10'b10000_01000,  // R3 smi ignored in mode
        10'b00001_01000,  // R7 iret opens, nothing pending
        10'b01000_01100,  // R7 nmi delivered after iret
        10'b00010_00010,  // R10 resume, halt=0
        10'b00000_00000,
        10'b10000_11000,  // R2 entry
        10'b01000_01000,  // R5 latched
        10'b00001_01100,  // R7 pending released on iret
        10'b00010_00010   // R6 nothing left pending
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        smi_req = 0; nmi_req = 0; core_halted = 0; rsm_retire = 0;
        iret_retire = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 active", {31'd0, smm_active}, 32'd0);
        check("R1 pulses", {27'd0, smm_enter, nmi_deliver, resume_valid, resume_halt, 1'b0}, 32'd0);
        check("R1 halt reg", reg_rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            {smi_req, nmi_req, core_halted, rsm_retire, iret_retire} = VEC[i][9:5];
            cyc();
            clear_inputs();
            check($sformatf("R2 enter v%0d", i), {31'd0, smm_enter}, {31'd0, VEC[i][4]});
            check($sformatf("R3 active v%0d", i), {31'd0, smm_active}, {31'd0, VEC[i][3]});
            check($sformatf("R5 deliver v%0d", i), {31'd0, nmi_deliver}, {31'd0, VEC[i][2]});
            check($sformatf("R10 resume v%0d", i), {31'd0, resume_valid}, {31'd0, VEC[i][1]});
            check($sformatf("R10 halt v%0d", i), {31'd0, resume_halt}, {31'd0, VEC[i][0]});
        end

        // R11 identifier, and writes do not change it
        reg_sel = 1; cyc();
        check("R11 ident", reg_rdata, 32'h0003_0000);
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc(); clear_inputs();
        reg_sel = 1; cyc();
        check("R11 ident after write", reg_rdata, 32'h0003_0000);
        clear_inputs();

        // R8 capture halted on entry
        smi_req = 1; core_halted = 1; cyc(); clear_inputs();
        check("R8 captured 1", reg_rdata, 32'd1);
        // R9 clear, then set back (entry value was 1)
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFE; cyc(); clear_inputs();
        check("R9 write 0", reg_rdata, 32'd0);
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc(); clear_inputs();
        check("R9 write 1 allowed", reg_rdata, 32'd1);
        check("R8 upper bits", reg_rdata & 32'hFFFF_FFFE, 32'd0);
        reg_wr = 1; reg_wdata = 32'd0; cyc(); clear_inputs();
        rsm_retire = 1; cyc(); clear_inputs();
        check("R10 halt follows written 0", {30'd0, resume_valid, resume_halt}, 32'd2);

        // R9 write 1 refused when entry value was 0
        smi_req = 1; core_halted = 0; cyc(); clear_inputs();
        check("R8 captured 0", reg_rdata, 32'd0);
        reg_wr = 1; reg_wdata = 32'd1; cyc(); clear_inputs();
        check("R9 write 1 refused", reg_rdata, 32'd0);
        rsm_retire = 1; cyc(); clear_inputs();
        check("R10 halt stays 0", {30'd0, resume_valid, resume_halt}, 32'd2);

        // R9 writes in normal mode are ignored
        smi_req = 1; core_halted = 1; cyc(); clear_inputs();
        rsm_retire = 1; cyc(); clear_inputs();
        check("R10 halt 1", {30'd0, resume_valid, resume_halt}, 32'd3);
        reg_wr = 1; reg_wdata = 32'd0; cyc(); clear_inputs();
        check("R9 normal-mode write ignored", reg_rdata, 32'd1);

        // R7 iret in normal mode has no effect; nmi still delivered
        iret_retire = 1; nmi_req = 1; cyc(); clear_inputs();
        check("R7 iret outside mode", {30'd0, smm_active, nmi_deliver}, 32'd1);
        cyc();
        check("R4 pulse one cycle", {31'd0, nmi_deliver}, 32'd0);

        // R5 nmi in the entry cycle is held, then R6 released on resume
        smi_req = 1; nmi_req = 1; cyc(); clear_inputs();
        check("R5 entry-cycle nmi held", {31'd0, nmi_deliver}, 32'd0);
        rsm_retire = 1; cyc(); clear_inputs();
        check("R6 released on resume", {30'd0, nmi_deliver, resume_valid}, 32'd3);

        // R1 reset from inside the mode
        smi_req = 1; cyc(); clear_inputs();
        rst_n = 0; cyc(); rst_n = 1;
        check("R1 reset clears mode", {31'd0, smm_active}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule